// File: doc/BRIEF.md
# Custom Instruction Dispatch Scheduler

This block sits beside the fetch stage of a base processor. It decides when a stretch of ordinary code is replaced by one custom instruction that runs on a reconfigurable unit. A small loadable table holds one entry per custom instruction. Each entry has a valid flag, the code address where the instruction begins, how many clock cycles the reconfigurable unit needs, and how many ordinary instructions the custom instruction replaces. When a presented PC hits a valid entry, the scheduler stops the processor's functional units and starts the reconfigurable unit with the index of the matching entry. The processor and the reconfigurable unit share operand and result ports, so they never run at the same time.

Once the stored number of cycles has passed, the scheduler steers the unit's results to the register-file write ports. The unit can produce more results than there are write ports. Results that do not fit are held and written one cycle later. The scheduler then issues a one-cycle redirect to the first address after the replaced code and lets the processor run again.

Top module: `ci_dispatch_sched`

## Requirements
- R1: After reset, halt_o, ru_start_o, redirect_o and every wb_en_o bit are low, and every table entry is invalid, so no PC starts a dispatch.
- R2: A cycle with tbl_we_i high writes entry tbl_idx_i with the given valid flag, address, cycle count and length. A hit needs the valid flag to be set, so writing the flag as 0 removes the entry.
- R3: When pc_valid_i is high in the idle state and pc_i equals the address of a valid entry, halt_o rises on the next cycle. In that same cycle ru_start_o is high for exactly one cycle and ru_cfg_o carries the index of the entry.
- R4: When several valid entries hold the same address, the entry with the lowest index is chosen.
- R5: The execute phase lasts C cycles, where C is the stored cycle count and a count of 0 is taken as 1. halt_o stays high for the whole phase, and the result inputs are used only in its last cycle.
- R6: In the last execute cycle, write port p (p = 0..3) carries result lane p: data in bits [32p+31:32p], destination in bits [5p+4:5p]. Its enable equals ru_mask_i[p].
- R7: If ru_mask_i[4] or ru_mask_i[5] was set in the last execute cycle, the next cycle keeps halt_o high and writes lanes 4 and 5 on ports 0 and 1, with enables equal to those mask bits. Ports 2 and 3 stay idle. If neither bit was set, this cycle is skipped.
- R8: The cycle after write-back, redirect_o is high for one cycle and halt_o is low. redirect_pc_o then equals the entry address plus 4 times its length. On the cycle after that the block is idle again.
- R9: A PC hit presented while the scheduler is not idle (execute, spill write-back or redirect cycle) is ignored.
- R10: The cycle count, length and address of the running instruction are latched at the hit. A table write during execution does not change them.
- R11: Outside the last execute cycle and the spill cycle, every wb_en_o bit is low, whatever the result inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | 32 | Fetch PC to compare against the table |
| pc_valid_i | input | 1 | pc_i is valid this cycle |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_idx_i | input | 3 | Entry to write |
| tbl_valid_i | input | 1 | Valid flag to store |
| tbl_addr_i | input | 32 | Custom instruction start address |
| tbl_cycles_i | input | 8 | Execution cycles (0 treated as 1) |
| tbl_len_i | input | 6 | Replaced code length in instructions |
| halt_o | output | 1 | Stops the processor's functional units |
| ru_start_o | output | 1 | One-cycle start pulse to the reconfigurable unit |
| ru_cfg_o | output | 3 | Configuration index of the dispatched entry |
| ru_res_i | input | 192 | Six 32-bit result lanes |
| ru_dst_i | input | 30 | Six 5-bit destination register numbers |
| ru_mask_i | input | 6 | Lane result valid bits |
| wb_en_o | output | 4 | Register-file write enables |
| wb_data_o | output | 128 | Write data per port |
| wb_dst_o | output | 20 | Destination register per port |
| redirect_o | output | 1 | PC redirect strobe |
| redirect_pc_o | output | 32 | PC after the replaced code |

## Verification
The hardest case to reach from the ports is a table write or a repeated hit that lands during an execution already in progress. It has to overlap exactly the window that the stored cycle count opens. Such a change must not stretch the stall, move the redirect target or start a second dispatch. The stimulus keeps pc_valid_i high on the matching address through the whole busy period, including the redirect cycle. In a random subset of dispatches it also rewrites the active entry in the first execute cycle with a new count and length. Directed cases add a zero cycle count, duplicate addresses in two entries, and masks with and without spilled lanes.

// File: rtl/ci_sched_pkg.sv
`timescale 1ns/1ps
package ci_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EXEC   = 2'd1,
    ST_WB2    = 2'd2,
    ST_RESUME = 2'd3
  } sched_state_e;

  localparam int unsigned INSN_SHIFT = 2;  // 4-byte instructions
endpackage

// File: rtl/ci_table.sv
`timescale 1ns/1ps
module ci_table #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned AW      = 32,
  parameter int unsigned CYC_W   = 8,
  parameter int unsigned LEN_W   = 6,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic             wvld_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [CYC_W-1:0] wcyc_i,
  input  logic [LEN_W-1:0] wlen_i,
  input  logic [AW-1:0]    pc_i,
  input  logic             pc_valid_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic [AW-1:0]    hit_addr_o,
  output logic [CYC_W-1:0] hit_cyc_o,
  output logic [LEN_W-1:0] hit_len_o
);
  logic [ENTRIES-1:0] vld_q;
  logic [AW-1:0]      addr_q [ENTRIES];
  logic [CYC_W-1:0]   cyc_q  [ENTRIES];
  logic [LEN_W-1:0]   len_q  [ENTRIES];
  logic [ENTRIES-1:0] hitv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (we_i) vld_q[widx_i] <= wvld_i;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      addr_q[widx_i] <= waddr_i;
      cyc_q[widx_i]  <= wcyc_i;
      len_q[widx_i]  <= wlen_i;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hitv[i] = vld_q[i] && (addr_q[i] == pc_i);
  end

  // lowest index wins
  always_comb begin
    hit_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitv[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o      = pc_valid_i && (|hitv);
  assign hit_addr_o = addr_q[hit_idx_o];
  assign hit_cyc_o  = cyc_q[hit_idx_o];
  assign hit_len_o  = len_q[hit_idx_o];

  // R2
  table_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> vld_q[$past(widx_i)] == $past(wvld_i));

  // R3
  hit_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (vld_q[hit_idx_o] && addr_q[hit_idx_o] == pc_i));
endmodule

// File: rtl/ci_wb_seq.sv
`timescale 1ns/1ps
module ci_wb_seq #(
  parameter int unsigned NOUT   = 6,
  parameter int unsigned WPORTS = 4,
  parameter int unsigned DW     = 32,
  parameter int unsigned RW     = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 capture_i,
  input  logic                 drain_i,
  input  logic [NOUT*DW-1:0]   res_i,
  input  logic [NOUT*RW-1:0]   dst_i,
  input  logic [NOUT-1:0]      mask_i,
  output logic                 spill_any_o,
  output logic [WPORTS-1:0]    wb_en_o,
  output logic [WPORTS*DW-1:0] wb_data_o,
  output logic [WPORTS*RW-1:0] wb_dst_o
);
  localparam int unsigned NSPILL = NOUT - WPORTS;

  logic [NSPILL-1:0]         sp_en_q;
  logic [NSPILL-1:0][DW-1:0] sp_data_q;
  logic [NSPILL-1:0][RW-1:0] sp_dst_q;

  assign spill_any_o = |mask_i[NOUT-1:WPORTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sp_en_q <= '0;
    else if (capture_i) sp_en_q <= mask_i[NOUT-1:WPORTS];
    else if (drain_i)   sp_en_q <= '0;
  end

  always_ff @(posedge clk_i) begin
    if (capture_i) begin
      for (int j = 0; j < NSPILL; j++) begin
        sp_data_q[j] <= res_i[(WPORTS+j)*DW +: DW];
        sp_dst_q[j]  <= dst_i[(WPORTS+j)*RW +: RW];
      end
    end
  end

  for (genvar p = 0; p < WPORTS; p++) begin : g_port
    if (p < NSPILL) begin : g_shared
      assign wb_en_o[p]            = (capture_i & mask_i[p]) | (drain_i & sp_en_q[p]);
      assign wb_data_o[p*DW +: DW] = drain_i ? sp_data_q[p] : res_i[p*DW +: DW];
      assign wb_dst_o[p*RW +: RW]  = drain_i ? sp_dst_q[p]  : dst_i[p*RW +: RW];
    end else begin : g_direct
      assign wb_en_o[p]            = capture_i & mask_i[p];
      assign wb_data_o[p*DW +: DW] = res_i[p*DW +: DW];
      assign wb_dst_o[p*RW +: RW]  = dst_i[p*RW +: RW];
    end
  end

  // R7
  spill_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> sp_en_q == $past(mask_i[NOUT-1:WPORTS]));

  // R11
  wb_mutex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(capture_i && drain_i));
endmodule

// File: rtl/ci_sched_fsm.sv
`timescale 1ns/1ps
module ci_sched_fsm
  import ci_sched_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CYC_W = 8,
  parameter int unsigned LEN_W = 6,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  input  logic [AW-1:0]    hit_addr_i,
  input  logic [CYC_W-1:0] hit_cyc_i,
  input  logic [LEN_W-1:0] hit_len_i,
  input  logic             spill_any_i,
  output logic             halt_o,
  output logic             ru_start_o,
  output logic [IDX_W-1:0] ru_cfg_o,
  output logic             capture_o,
  output logic             drain_o,
  output logic             redirect_o,
  output logic [AW-1:0]    redirect_pc_o
);
  function automatic logic [AW-1:0] skip_pc(input logic [AW-1:0] base,
                                            input logic [LEN_W-1:0] n);
    return base + (AW'(n) << INSN_SHIFT);
  endfunction

  function automatic logic [CYC_W-1:0] eff_cycles(input logic [CYC_W-1:0] c);
    return (c == '0) ? CYC_W'(1) : c;
  endfunction

  sched_state_e     state_q;
  logic [CYC_W-1:0] cnt_q, cyc_lat_q, exec_age_q;
  logic [AW-1:0]    tgt_q;
  logic [IDX_W-1:0] cfg_q;
  logic             start_q;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      cyc_lat_q <= '0;
      tgt_q     <= '0;
      cfg_q     <= '0;
      start_q   <= 1'b0;
    end else begin
      start_q <= accept;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_EXEC;
          cnt_q     <= eff_cycles(hit_cyc_i);
          cyc_lat_q <= eff_cycles(hit_cyc_i);
          tgt_q     <= skip_pc(hit_addr_i, hit_len_i);
          cfg_q     <= hit_idx_i;
        end
        ST_EXEC: begin
          if (cnt_q == CYC_W'(1)) state_q <= spill_any_i ? ST_WB2 : ST_RESUME;
          else                    cnt_q   <= cnt_q - 1'b1;
        end
        ST_WB2:    state_q <= ST_RESUME;
        ST_RESUME: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign halt_o        = (state_q == ST_EXEC) || (state_q == ST_WB2);
  assign ru_start_o    = start_q;
  assign ru_cfg_o      = cfg_q;
  assign capture_o     = (state_q == ST_EXEC) && (cnt_q == CYC_W'(1));
  assign drain_o       = (state_q == ST_WB2);
  assign redirect_o    = (state_q == ST_RESUME);
  assign redirect_pc_o = tgt_q;

  // independent cycle counter for the execute window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 exec_age_q <= CYC_W'(1);
    else if (state_q != ST_EXEC) exec_age_q <= CYC_W'(1);
    else                         exec_age_q <= exec_age_q + 1'b1;
  end

  // R5
  exec_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> exec_age_q == cyc_lat_q);

  // R3
  start_with_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> ru_start_o);

  // R8
  resume_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> (!halt_o && !redirect_o));

  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> !ru_start_o);

  // R7
  spill_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && spill_any_i) |=> drain_o);
endmodule

// File: rtl/ci_dispatch_sched.sv
`timescale 1ns/1ps
module ci_dispatch_sched #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned AW      = 32,
  parameter int unsigned CYC_W   = 8,
  parameter int unsigned LEN_W   = 6,
  parameter int unsigned DW      = 32,
  parameter int unsigned RW      = 5,
  parameter int unsigned NOUT    = 6,
  parameter int unsigned WPORTS  = 4,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [AW-1:0]        pc_i,
  input  logic                 pc_valid_i,
  input  logic                 tbl_we_i,
  input  logic [IDX_W-1:0]     tbl_idx_i,
  input  logic                 tbl_valid_i,
  input  logic [AW-1:0]        tbl_addr_i,
  input  logic [CYC_W-1:0]     tbl_cycles_i,
  input  logic [LEN_W-1:0]     tbl_len_i,
  output logic                 halt_o,
  output logic                 ru_start_o,
  output logic [IDX_W-1:0]     ru_cfg_o,
  input  logic [NOUT*DW-1:0]   ru_res_i,
  input  logic [NOUT*RW-1:0]   ru_dst_i,
  input  logic [NOUT-1:0]      ru_mask_i,
  output logic [WPORTS-1:0]    wb_en_o,
  output logic [WPORTS*DW-1:0] wb_data_o,
  output logic [WPORTS*RW-1:0] wb_dst_o,
  output logic                 redirect_o,
  output logic [AW-1:0]        redirect_pc_o
);
  logic             hit, spill_any, capture, drain;
  logic [IDX_W-1:0] hit_idx;
  logic [AW-1:0]    hit_addr;
  logic [CYC_W-1:0] hit_cyc;
  logic [LEN_W-1:0] hit_len;

  ci_table #(.ENTRIES(ENTRIES), .AW(AW), .CYC_W(CYC_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(tbl_we_i), .widx_i(tbl_idx_i), .wvld_i(tbl_valid_i),
    .waddr_i(tbl_addr_i), .wcyc_i(tbl_cycles_i), .wlen_i(tbl_len_i),
    .pc_i(pc_i), .pc_valid_i(pc_valid_i),
    .hit_o(hit), .hit_idx_o(hit_idx), .hit_addr_o(hit_addr),
    .hit_cyc_o(hit_cyc), .hit_len_o(hit_len)
  );

  ci_sched_fsm #(.AW(AW), .CYC_W(CYC_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hit_i(hit), .hit_idx_i(hit_idx), .hit_addr_i(hit_addr),
    .hit_cyc_i(hit_cyc), .hit_len_i(hit_len), .spill_any_i(spill_any),
    .halt_o(halt_o), .ru_start_o(ru_start_o), .ru_cfg_o(ru_cfg_o),
    .capture_o(capture), .drain_o(drain),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  ci_wb_seq #(.NOUT(NOUT), .WPORTS(WPORTS), .DW(DW), .RW(RW)) u_wb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .capture_i(capture), .drain_i(drain),
    .res_i(ru_res_i), .dst_i(ru_dst_i), .mask_i(ru_mask_i),
    .spill_any_o(spill_any),
    .wb_en_o(wb_en_o), .wb_data_o(wb_data_o), .wb_dst_o(wb_dst_o)
  );

  // R11
  wb_only_halted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o != '0) |-> halt_o);

  // R8
  redirect_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> !halt_o);
endmodule

// File: tb/tb_ci_dispatch_sched.sv
`timescale 1ns/1ps
module tb_ci_dispatch_sched;
  localparam int ENTRIES = 8, AW = 32, CYC_W = 8, LEN_W = 6;
  localparam int DW = 32, RW = 5, NOUT = 6, WPORTS = 4, IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] pc = '0;
  logic pc_valid = 1'b0;
  logic tbl_we = 1'b0, tbl_valid = 1'b0;
  logic [IDX_W-1:0] tbl_idx = '0;
  logic [AW-1:0] tbl_addr = '0;
  logic [CYC_W-1:0] tbl_cycles = '0;
  logic [LEN_W-1:0] tbl_len = '0;
  logic halt, ru_start, redirect;
  logic [IDX_W-1:0] ru_cfg;
  logic [NOUT*DW-1:0] ru_res = '0;
  logic [NOUT*RW-1:0] ru_dst = '0;
  logic [NOUT-1:0] ru_mask = '0;
  logic [WPORTS-1:0] wb_en;
  logic [WPORTS*DW-1:0] wb_data;
  logic [WPORTS*RW-1:0] wb_dst;
  logic [AW-1:0] redirect_pc;

  int n_chk = 0, n_err = 0;
  bit m_vld [ENTRIES];
  logic [AW-1:0] m_addr [ENTRIES];
  logic [CYC_W-1:0] m_cyc [ENTRIES];
  logic [LEN_W-1:0] m_len [ENTRIES];

  always #2.5 clk = ~clk;

  ci_dispatch_sched dut (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .pc_valid_i(pc_valid),
    .tbl_we_i(tbl_we), .tbl_idx_i(tbl_idx), .tbl_valid_i(tbl_valid),
    .tbl_addr_i(tbl_addr), .tbl_cycles_i(tbl_cycles), .tbl_len_i(tbl_len),
    .halt_o(halt), .ru_start_o(ru_start), .ru_cfg_o(ru_cfg),
    .ru_res_i(ru_res), .ru_dst_i(ru_dst), .ru_mask_i(ru_mask),
    .wb_en_o(wb_en), .wb_data_o(wb_data), .wb_dst_o(wb_dst),
    .redirect_o(redirect), .redirect_pc_o(redirect_pc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int model_hit(input logic [AW-1:0] a);
    for (int i = 0; i < ENTRIES; i++)
      if (m_vld[i] && m_addr[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [AW-1:0] model_target(input logic [AW-1:0] a, input logic [LEN_W-1:0] n);
    return a + 32'(n) * 4;
  endfunction

  task automatic load(input int idx, input bit v, input logic [AW-1:0] a,
                      input logic [CYC_W-1:0] c, input logic [LEN_W-1:0] n);
    tbl_we = 1'b1; tbl_idx = IDX_W'(idx); tbl_valid = v;
    tbl_addr = a; tbl_cycles = c; tbl_len = n;
    tick();
    tbl_we = 1'b0;
    m_vld[idx] = v; m_addr[idx] = a; m_cyc[idx] = c; m_len[idx] = n;
  endtask

  task automatic rand_results();
    for (int l = 0; l < NOUT; l++) begin
      ru_res[l*DW +: DW] = $urandom;
      ru_dst[l*RW +: RW] = RW'($urandom);
    end
  endtask

  // one dispatch attempt, cycle by cycle against the model
  task automatic dispatch(input logic [AW-1:0] a, input logic [NOUT-1:0] mask,
                          input bit keep_pc, input bit rewrite);
    int e, ec;
    logic [AW-1:0] tgt;
    logic [NOUT*DW-1:0] res_s;
    logic [NOUT*RW-1:0] dst_s;
    e = model_hit(a);
    pc = a; pc_valid = 1'b1;
    tick();
    #1;
    if (e < 0) begin
      chk("R2 miss no halt", halt, 0);
      chk("R2 miss no start", ru_start, 0);
      pc_valid = 1'b0;
      return;
    end
    ec  = (m_cyc[e] == 0) ? 1 : int'(m_cyc[e]);
    tgt = model_target(m_addr[e], m_len[e]);
    if (!keep_pc) pc_valid = 1'b0;
    if (rewrite) begin
      tbl_we = 1'b1; tbl_idx = IDX_W'(e); tbl_valid = 1'b1; tbl_addr = a;
      tbl_cycles = CYC_W'(1 + ($urandom % 5)); tbl_len = LEN_W'($urandom);
      m_cyc[e] = tbl_cycles; m_len[e] = tbl_len;
    end
    for (int k = 1; k <= ec; k++) begin
      rand_results();
      ru_mask = NOUT'($urandom);
      if (k == ec) begin
        ru_mask = mask; res_s = ru_res; dst_s = ru_dst;
      end
      #0.5;
      chk("R5 halt during exec", halt, 1);
      chk("R3 start pulse", ru_start, (k == 1) ? 1 : 0);
      if (k == 1) chk("R3/R4 cfg index", ru_cfg, e);
      if (k < ec) chk("R11 no write before last cycle", wb_en, 0);
      else begin
        chk("R6 port enables", wb_en, mask[3:0]);
        for (int p = 0; p < WPORTS; p++)
          if (mask[p]) begin
            chk("R6 port data", wb_data[p*DW +: DW], res_s[p*DW +: DW]);
            chk("R6 port dst", wb_dst[p*RW +: RW], dst_s[p*RW +: RW]);
          end
      end
      tick();
      tbl_we = 1'b0;
    end
    rand_results();
    ru_mask = NOUT'($urandom);
    #1;
    if (mask[5:4] != 2'b00) begin
      chk("R7 halt in spill", halt, 1);
      chk("R7 spill enables", wb_en, {2'b00, mask[5:4]});
      for (int j = 0; j < 2; j++)
        if (mask[4+j]) begin
          chk("R7 spill data", wb_data[j*DW +: DW], res_s[(4+j)*DW +: DW]);
          chk("R7 spill dst", wb_dst[j*RW +: RW], dst_s[(4+j)*RW +: RW]);
        end
      tick();
      #1;
    end
    chk("R8 redirect", redirect, 1);
    chk("R8 redirect pc", redirect_pc, tgt);
    chk("R8 halt released", halt, 0);
    chk("R11 no write in redirect", wb_en, 0);
    tick();
    pc_valid = 1'b0;
    #1;
    chk("R9/R8 idle after redirect", halt, 0);
    chk("R9 no restart", ru_start, 0);
    chk("R8 redirect single", redirect, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < ENTRIES; i++) m_vld[i] = 1'b0;
    repeat (3) tick();
    #1;
    chk("R1 halt at reset", halt, 0);
    chk("R1 start at reset", ru_start, 0);
    chk("R1 redirect at reset", redirect, 0);
    chk("R1 wb at reset", wb_en, 0);
    rst_n = 1'b1;
    tick();
    dispatch(32'h0000_1000, 6'h3F, 0, 0);  // R1 empty table: no hit

    for (int i = 0; i < ENTRIES; i++)
      load(i, 1'b1, 32'h0001_0000 + 32'(i) * 32'h100 + (($urandom % 16) << 2),
           CYC_W'(1 + ($urandom % 6)), LEN_W'(1 + ($urandom % 30)));
    load(5, 1'b1, m_addr[5], 8'd0, 6'd7);   // R5 zero count taken as one
    load(6, 1'b0, m_addr[6], 8'd3, 6'd2);   // R2 invalid entry

    dispatch(m_addr[0], 6'h3F, 0, 0);
    dispatch(m_addr[1], 6'h0F, 0, 0);
    dispatch(m_addr[2], 6'h10, 0, 0);
    dispatch(m_addr[3], 6'h20, 1, 0);       // R9 hit held during busy
    dispatch(m_addr[4], 6'h00, 0, 1);       // R10 rewrite while running
    dispatch(m_addr[5], 6'h31, 0, 0);
    dispatch(m_addr[6], 6'h3F, 0, 0);       // R2 invalid: no dispatch

    load(7, 1'b1, m_addr[2], 8'd2, 6'd3);   // R4 duplicate address
    dispatch(m_addr[2], 6'h3F, 0, 0);
    load(2, 1'b0, m_addr[2], 8'd1, 6'd1);   // R2 remove, entry 7 takes over
    dispatch(m_addr[7], 6'h15, 1, 0);

    for (int t = 0; t < 60; t++) begin
      logic [AW-1:0] a;
      int pick;
      pick = $urandom % ENTRIES;
      a = ($urandom % 10 < 7) ? m_addr[pick] : ($urandom & 32'hFFFF_FFFC);
      dispatch(a, NOUT'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule